// File: doc/BRIEF.md
# Grid Scan Watchdog Blanker

This block guards a multiplexed vacuum fluorescent display against a stalled grid scan. It watches a scan activity signal, normally the serial output at the end of the grid shift chain, through a two-flop synchronizer and an edge detector. Each detected activity edge restarts a retriggerable timeout whose length, in clock cycles, is set by the host. While the timeout runs, the host's own blanking request passes straight through to the blanking output. When the timeout expires, or before the first activity edge after reset, the block forces blanking so that every driver output turns off.

An expiry also sets a sticky fault flag and drops the display supply enable. The flag stays set until the host clears it. After a clear, blanking stays forced until a new activity edge arrives. The window should cover a few refresh periods. At a 120 Hz refresh one period is about 8.3 ms, so the default counter width holds several periods at clock rates of a few hundred MHz.

Top module: `scan_guard`

## Requirements
- R1: After reset, and until the first activity edge, blank_o is 1, fault_o is 0 and supply_en_o is 1.
- R2: With the default edge select, both rising and falling transitions of scan_act_i count as activity. A transition that is set up before clock edge k releases the watchdog blanking after edge k+2. That edge is the retrigger edge.
- R3: With window W (W >= 1), if no activity edge follows the retrigger edge e, blank_o rises and fault_o sets after edge e+W. blank_o stays 0 through edge e+W-1.
- R4: blank_o is the OR of host_blank_i and the watchdog's own blanking, at all times.
- R5: fault_o stays 1 until fault_clr_i is sampled high. While fault_o is 1, activity edges neither clear it nor release blanking.
- R6: supply_en_o is 0 exactly while fault_o is 1.
- R7: A clear sampled at the same edge as an activity edge clears fault_o, but that edge does not retrigger. blank_o stays 1 until a later activity edge retriggers.
- R8: win_cycles_i is sampled on every cycle. A value of 0 acts as 1 (expiry one edge after the retrigger). The largest value, 2^CNT_W-1, gives a window of that many cycles.
- R9: A scan_act_i level that is held constant, high or low, is not activity, and the window runs out as if the scan had stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_act_i | input | 1 | Scan activity, asynchronous to clk_i |
| host_blank_i | input | 1 | Host blanking request, 1 = outputs off |
| win_cycles_i | input | CNT_W | Timeout window in clock cycles |
| fault_clr_i | input | 1 | Clears the sticky fault flag |
| blank_o | output | 1 | Combined blanking, 1 = all driver outputs off |
| supply_en_o | output | 1 | Display supply enable, 0 after a fault |
| fault_o | output | 1 | Sticky watchdog expiry flag |

## Verification
The bench builds the block with CNT_W = 8 and both edges selected. With that width the largest window, 255 cycles, can be reached in a short run, as can the zero window. Directed phases exercise the synchronizer latency, exact expiry edges, host blanking, a clear that lands on the same edge as activity, and changes of the window while the timer runs. These are followed by a random toggle phase with random windows and clears. A behavioural model in the bench compares all three outputs on every cycle.

// File: rtl/scan_guard_pkg.sv
package scan_guard_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_BOTH = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/sg_edge_sync.sv
module sg_edge_sync
  import scan_guard_pkg::*;
#(
  parameter edge_sel_e EDGE_SEL = EDGE_BOTH,
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              level;

  assign level = sync_q[SYNC_N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], async_i};
      prev_q <= level;
    end
  end

  generate
    if (EDGE_SEL == EDGE_BOTH) begin : g_both
      assign pulse_o = level ^ prev_q;
    end else begin : g_rise
      assign pulse_o = level & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/sg_retrig_timer.sv
module sg_retrig_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kick_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] win_i,
  output logic             run_o,
  output logic             expire_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   cnt_inc;
  logic             kick_ok;

  // zero window behaves as one cycle
  assign lim      = (win_i == '0) ? CNT_W'(1) : win_i;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign kick_ok  = kick_i & ~hold_i;
  assign expire_o = run_q & ~kick_ok & (cnt_inc >= {1'b0, lim});
  assign run_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (kick_ok) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (expire_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/sg_fault_latch.sv
module sg_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o
);
  logic fault_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fault_q <= 1'b0;
    else if (set_i)  fault_q <= 1'b1;
    else if (clr_i)  fault_q <= 1'b0;
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/scan_guard.sv
module scan_guard
  import scan_guard_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter edge_sel_e   EDGE_SEL = EDGE_BOTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_act_i,
  input  logic             host_blank_i,
  input  logic [CNT_W-1:0] win_cycles_i,
  input  logic             fault_clr_i,
  output logic             blank_o,
  output logic             supply_en_o,
  output logic             fault_o
);
  logic act_pulse;
  logic tmr_run;
  logic tmr_exp;
  logic fault;

  sg_edge_sync #(
    .EDGE_SEL (EDGE_SEL),
    .SYNC_N   (2)
  ) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (scan_act_i),
    .pulse_o (act_pulse)
  );

  sg_retrig_timer #(
    .CNT_W (CNT_W)
  ) i_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (act_pulse),
    .hold_i   (fault),
    .win_i    (win_cycles_i),
    .run_o    (tmr_run),
    .expire_o (tmr_exp)
  );

  sg_fault_latch i_flt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (tmr_exp),
    .clr_i   (fault_clr_i),
    .fault_o (fault)
  );

  assign blank_o     = host_blank_i | ~tmr_run;
  assign supply_en_o = ~fault;
  assign fault_o     = fault;
endmodule

// File: rtl/scan_guard_chk.sv
module scan_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic host_blank_i,
  input logic fault_clr_i,
  input logic blank_o,
  input logic supply_en_o,
  input logic fault_o,
  input logic tmr_run
);
  // R4
  host_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_blank_i |-> blank_o);

  // R5
  fault_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i) |=> fault_o);

  // R5
  fault_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> blank_o);

  // R3
  fault_from_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(tmr_run));

  // R6
  fault_cuts_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !supply_en_o);

  // R7
  clear_keeps_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> blank_o);
endmodule

bind scan_guard scan_guard_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_blank_i (host_blank_i),
  .fault_clr_i  (fault_clr_i),
  .blank_o      (blank_o),
  .supply_en_o  (supply_en_o),
  .fault_o      (fault_o),
  .tmr_run      (tmr_run)
);

// File: tb/test_scan_guard.sv
`timescale 1ns/1ps
module test_scan_guard;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             scan = 1'b0;
  logic             host = 1'b0;
  logic [CNT_W-1:0] win = '0;
  logic             clr = 1'b0;
  logic             blank, supply, fault;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  scan_guard #(.CNT_W(CNT_W)) i_scan_guard (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scan_act_i   (scan),
    .host_blank_i (host),
    .win_cycles_i (win),
    .fault_clr_i  (clr),
    .blank_o      (blank),
    .supply_en_o  (supply),
    .fault_o      (fault)
  );

  // behavioural reference
  bit h1, h2, h3;
  bit m_alive, m_flt;
  int m_since;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0;
      m_alive = 0; m_flt = 0; m_since = 0;
    end else begin
      bit p, old_f;
      int lim;
      p = (h2 != h3);
      old_f = m_flt;
      lim = (int'(win) == 0) ? 1 : int'(win);
      if (clr) m_flt = 0;
      if (p && !old_f) begin
        m_alive = 1; m_since = 0;
      end else if (m_alive) begin
        m_since++;
        if (m_since >= lim) begin m_alive = 0; m_flt = 1; end
      end
      h3 = h2; h2 = h1; h1 = scan;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 model blank", blank, host | ~m_alive);
      chk("R5 model fault", fault, m_flt);
      chk("R6 model supply", supply, ~m_flt);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    win = 8'd6;
    step(3);
    rst_n = 1'b1;
    // R1 reset state, R9 static level
    step(1);
    chk("R1 blank after reset", blank, 1'b1);
    chk("R1 fault after reset", fault, 1'b0);
    chk("R1 supply after reset", supply, 1'b1);
    scan = 1'b1;  // held high: not activity beyond one edge
    step(2);
    chk("R2 still blanked after edge k+1", blank, 1'b1);
    step(1);
    chk("R2 released after edge k+2", blank, 1'b0);
    // keep scanning with both edges
    for (int i = 0; i < 12; i++) begin
      scan = ~scan;
      step(4);
      chk("R2 running scan keeps unblanked", blank, 1'b0);
    end
    chk("R9 no fault while scanning", fault, 1'b0);
    // R3 exact expiry: toggle then stop
    scan = ~scan;
    step(3);
    chk("R3 unblanked at retrigger", blank, 1'b0);
    step(5);
    chk("R3 unblanked at e+W-1", blank, 1'b0);
    step(1);
    chk("R3 blank at e+W", blank, 1'b1);
    chk("R3 fault at e+W", fault, 1'b1);
    chk("R6 supply off", supply, 1'b0);
    // R5 activity does not clear fault
    for (int i = 0; i < 4; i++) begin
      scan = ~scan;
      step(3);
    end
    chk("R5 fault sticky under activity", fault, 1'b1);
    chk("R5 blank sticky under activity", blank, 1'b1);
    // R7 clear on same edge as activity pulse
    step(4);
    scan = ~scan;
    step(1);             // after edge k
    @(posedge clk);      // edge k+1
    @(negedge clk);
    clr = 1'b1;
    step(1);             // edge k+2: pulse and clear together
    clr = 1'b0;
    chk("R7 fault cleared", fault, 1'b0);
    chk("R6 supply back", supply, 1'b1);
    chk("R7 blank kept after clear", blank, 1'b1);
    step(10);
    chk("R7 blank kept without fresh edge", blank, 1'b1);
    scan = ~scan;
    step(3);
    chk("R7 fresh edge releases", blank, 1'b0);
    // R4 host blanking
    host = 1'b1;
    #0.1;
    chk("R4 host forces blank", blank, 1'b1);
    scan = ~scan;
    step(1);
    host = 1'b0;
    #0.1;
    chk("R4 host released", blank, 1'b0);
    // R8 zero window
    win = 8'd0;
    step(4);
    chk("R8 zero window expired", fault, 1'b1);
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R5 clear via fault_clr_i", fault, 1'b0);
    // R8 max window
    win = 8'd255;
    scan = ~scan;
    step(3);
    chk("R8 max window retrigger", blank, 1'b0);
    step(254);
    chk("R8 unblanked at e+254", blank, 1'b0);
    step(1);
    chk("R8 expiry at e+255", fault, 1'b1);
    clr = 1'b1; step(1); clr = 1'b0;
    // R9 static low level
    scan = 1'b0;
    win = 8'd4;
    step(3);
    step(6);
    chk("R9 held level stalls", blank, 1'b1);
    clr = 1'b1; step(1); clr = 1'b0;
    // random phase, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) scan = ~scan;
      if ($urandom_range(0, 63) == 0) win = 8'($urandom_range(0, 12));
      host = ($urandom_range(0, 15) == 0);
      clr  = ($urandom_range(0, 31) == 0);
      step(1);
    end
    host = 1'b0; clr = 1'b0;
    step(2);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule